// File: doc/BRIEF.md
# I/O Instruction Bus Cycle Sequencer

This block is a small bus master for an 8-bit processor bus with a multiplexed low address/data byte. It runs only four instructions: port output, port input, direct store and direct load. It holds an accumulator and a program counter. It fetches each opcode and its operand bytes from memory, one bus cycle per byte, and then runs the final transfer cycle against an I/O port or a memory location. After that it moves on to the next opcode and keeps going for as long as it is clocked.

Each clock is one T-state. The opcode fetch cycle lasts four T-states, and every other cycle lasts three.

- **T1:** the address strobe is high. The high address byte is on `addr_hi` and the low byte is on `bus_out`.
- **T2 and T3:** the read or write strobe is low.
  - In a read, the bus is released and `bus_in` is captured at the clock edge that ends T3.
  - In a write, the accumulator is driven on `bus_out`.
- **T4:** fetch only. The bus is idle while the opcode is decoded.

The state is a pair of registers: the machine-cycle kind (FETCH, OPND_LO, OPND_HI, PORT_WR, PORT_RD, MEM_WR, MEM_RD) and the T-state (TS_1 to TS_4). The T-state transitions are:

- TS_1 goes to TS_2, and TS_2 goes to TS_3.
- TS_3 goes to TS_4 in FETCH. In any other cycle it goes to TS_1 of the next cycle.
- TS_4 goes to FETCH/TS_1 for an unsupported opcode, and otherwise to OPND_LO/TS_1.

The machine-cycle transitions are:

- OPND_LO goes to PORT_WR for D3H, to PORT_RD for DBH, and otherwise to OPND_HI.
- OPND_HI goes to MEM_WR for 32H and to MEM_RD for 3AH.
- PORT_WR, PORT_RD, MEM_WR and MEM_RD all go to FETCH.

Top module: `ioseq_core`

## Requirements
- R1: While reset is held and just after it is released, the block is in T1 of an opcode fetch at address 0000H, with `rd_n` and `wr_n` high.
- R2: The opcode fetch cycle takes four T-states.
  - T1: `addr_strobe`=1, `io_cycle`=0, `bus_oe`=1, and the PC on `addr_hi`/`bus_out`.
  - T2 and T3: `rd_n`=0 and `bus_oe`=0.
  - T4: both strobes high and `bus_oe`=0.
  - The opcode is the `bus_in` byte at the end of T3.
- R3: Each operand byte is read in a three-T-state memory read at the next PC value. The PC advances by one after every fetched byte, and a 16-bit address is taken low byte first.
- R4: Opcode D3H (port output, 2 bytes) takes 4+3+3 T-states.
  - Final cycle: `io_cycle`=1, with the port number on both `addr_hi` and `bus_out` in T1.
  - `wr_n`=0 in T2 and T3 only, with the accumulator on `bus_out`.
- R5: Opcode DBH (port input, 2 bytes) takes 4+3+3 T-states.
  - Final cycle: `io_cycle`=1, the port number on both address halves in T1, and `rd_n`=0 in T2 and T3.
  - The `bus_in` byte at the end of T3 becomes the accumulator.
- R6: Opcode 32H (direct store, 3 bytes) takes 4+3+3+3 T-states. The final cycle drives the 16-bit operand address with `io_cycle`=0 and writes the accumulator with `wr_n`=0 in T2 and T3.
- R7: Opcode 3AH (direct load, 3 bytes) takes 4+3+3+3 T-states. The final cycle is a memory read at the 16-bit operand address, and the captured byte becomes the accumulator.
- R8: Any other opcode ends after its four-T-state fetch. The next fetch starts at the following address and the accumulator is unchanged.
- R9: `addr_strobe` is high only in T1, which lasts one clock, and `rd_n` and `wr_n` are never low together.
- R10: `bus_oe` is low whenever `rd_n` is low.
- R11: The accumulator resets to 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Byte returned by memory or port during reads |
| bus_out | output | 8 | Low address in T1, write data in T2/T3 of writes |
| bus_oe | output | 1 | High when `bus_out` is driven |
| addr_hi | output | 8 | High address byte, held for the whole cycle |
| addr_strobe | output | 1 | High in T1; marks a valid low address |
| io_cycle | output | 1 | 1 for port cycles, 0 for memory cycles |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench watches for several specific faults:

- A port cycle that put the port number on only one address half, or took the full 16-bit address, would show a wrong `addr_hi` in the final T1.
- A store whose operand bytes were swapped would write to the wrong location.
- A decoder that treated an unknown opcode as two bytes long would skip the next opcode.

A directed prologue covers several edge cases:

- An output issued straight after reset, where a non-zero accumulator would show up.
- A port number of FFH.
- The highest data address.
- A store followed by a load of the same location, which would expose a write with the wrong data or timing.

Random programs then mix all four instructions with unknown opcodes. In these runs, a strobe held one clock too long, or a bus left driven during a read, breaks the per-T-state trace.

// File: rtl/ioseq_pkg.sv
package ioseq_pkg;

    // Machine-cycle kinds
    typedef enum logic [2:0] {
        MC_FETCH,
        MC_OPND_LO,
        MC_OPND_HI,
        MC_PORT_WR,
        MC_PORT_RD,
        MC_MEM_WR,
        MC_MEM_RD
    } mcyc_e;

    // T-states within a machine cycle
    typedef enum logic [1:0] {
        TS_1,
        TS_2,
        TS_3,
        TS_4
    } tstate_e;

    // Instruction classes
    typedef enum logic [2:0] {
        K_NONE,
        K_PORT_OUT,
        K_PORT_IN,
        K_STORE,
        K_LOAD
    } kind_e;

    localparam logic [7:0] OPC_PORT_OUT = 8'hD3;
    localparam logic [7:0] OPC_PORT_IN  = 8'hDB;
    localparam logic [7:0] OPC_STORE    = 8'h32;
    localparam logic [7:0] OPC_LOAD     = 8'h3A;

    // Register load controls raised by the sequencer
    typedef struct packed {
        logic       ld_opcode;
        logic [1:0] ld_opnd;    // [0] low operand, [1] high operand
        logic       ld_acc;
        logic       pc_inc;
    } reg_ctl_t;

    function automatic logic cyc_is_write(mcyc_e c);
        return (c == MC_PORT_WR) || (c == MC_MEM_WR);
    endfunction

    function automatic logic cyc_is_port(mcyc_e c);
        return (c == MC_PORT_WR) || (c == MC_PORT_RD);
    endfunction

endpackage

// File: rtl/ioseq_decode.sv
module ioseq_decode
    import ioseq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] opcode,
    output kind_e             kind
);

    always_comb begin
        unique case (opcode)
            DATA_W'(OPC_PORT_OUT): kind = K_PORT_OUT;
            DATA_W'(OPC_PORT_IN):  kind = K_PORT_IN;
            DATA_W'(OPC_STORE):    kind = K_STORE;
            DATA_W'(OPC_LOAD):     kind = K_LOAD;
            default:               kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/ioseq_fsm.sv
module ioseq_fsm
    import ioseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  kind_e    kind,
    output mcyc_e    mcyc,
    output tstate_e  tst,
    output reg_ctl_t rctl
);

    mcyc_e   nx_mcyc;
    tstate_e nx_tst;

    // Cycle that follows the last T-state of a three-T-state cycle
    function automatic mcyc_e after_short(mcyc_e c, kind_e k);
        mcyc_e r;
        unique case (c)
            MC_OPND_LO: begin
                unique case (k)
                    K_PORT_OUT: r = MC_PORT_WR;
                    K_PORT_IN:  r = MC_PORT_RD;
                    default:    r = MC_OPND_HI;
                endcase
            end
            MC_OPND_HI: r = (k == K_STORE) ? MC_MEM_WR : MC_MEM_RD;
            default:    r = MC_FETCH;
        endcase
        return r;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcyc <= MC_FETCH;
            tst  <= TS_1;
        end else begin
            mcyc <= nx_mcyc;
            tst  <= nx_tst;
        end
    end

    // Transitions
    always_comb begin
        nx_mcyc = mcyc;
        nx_tst  = tst;
        unique case (tst)
            TS_1: nx_tst = TS_2;
            TS_2: nx_tst = TS_3;
            TS_3: begin
                if (mcyc == MC_FETCH) begin
                    nx_tst = TS_4;
                end else begin
                    nx_tst  = TS_1;
                    nx_mcyc = after_short(mcyc, kind);
                end
            end
            TS_4: begin
                nx_tst  = TS_1;
                nx_mcyc = (kind == K_NONE) ? MC_FETCH : MC_OPND_LO;
            end
        endcase
    end

    // Register load strobes, all taken on the edge that ends T3
    always_comb begin
        rctl = '0;
        if (tst == TS_3) begin
            unique case (mcyc)
                MC_FETCH: begin
                    rctl.ld_opcode = 1'b1;
                    rctl.pc_inc    = 1'b1;
                end
                MC_OPND_LO: begin
                    rctl.ld_opnd[0] = 1'b1;
                    rctl.pc_inc     = 1'b1;
                end
                MC_OPND_HI: begin
                    rctl.ld_opnd[1] = 1'b1;
                    rctl.pc_inc     = 1'b1;
                end
                MC_PORT_RD, MC_MEM_RD: rctl.ld_acc = 1'b1;
                default: rctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/ioseq_regs.sv
module ioseq_regs
    import ioseq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RESET_PC = 0,
    localparam int unsigned ADDR_W  = 2 * DATA_W,
    localparam int unsigned N_OPND  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_ctl_t          rctl,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] opcode,
    output logic [DATA_W-1:0] opnd_lo,
    output logic [DATA_W-1:0] opnd_hi,
    output logic [DATA_W-1:0] acc
);

    logic [N_OPND-1:0][DATA_W-1:0] opnd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= ADDR_W'(RESET_PC);
            opcode <= '0;
            acc    <= '0;
        end else begin
            if (rctl.pc_inc)    pc     <= pc + ADDR_W'(1);
            if (rctl.ld_opcode) opcode <= bus_in;
            if (rctl.ld_acc)    acc    <= bus_in;
        end
    end

    // One capture register per operand byte
    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               opnd[i] <= '0;
            else if (rctl.ld_opnd[i]) opnd[i] <= bus_in;
        end
    end

    assign opnd_lo = opnd[0];
    assign opnd_hi = opnd[1];

endmodule

// File: rtl/ioseq_busdrv.sv
module ioseq_busdrv
    import ioseq_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  mcyc_e             mcyc,
    input  tstate_e           tst,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] opnd_lo,
    input  logic [DATA_W-1:0] opnd_hi,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] addr_hi,
    output logic              addr_strobe,
    output logic              io_cycle,
    output logic              rd_n,
    output logic              wr_n
);

    logic [ADDR_W-1:0] cyc_addr;
    logic              is_wr;

    // Address used by the current machine cycle
    always_comb begin
        unique case (mcyc)
            MC_FETCH, MC_OPND_LO, MC_OPND_HI: cyc_addr = pc;
            MC_PORT_WR, MC_PORT_RD:           cyc_addr = {opnd_lo, opnd_lo};
            default:                          cyc_addr = {opnd_hi, opnd_lo};
        endcase
    end

    assign is_wr = cyc_is_write(mcyc);

    // Pin outputs
    always_comb begin
        addr_hi     = cyc_addr[ADDR_W-1:DATA_W];
        io_cycle    = cyc_is_port(mcyc);
        addr_strobe = 1'b0;
        rd_n        = 1'b1;
        wr_n        = 1'b1;
        bus_oe      = 1'b0;
        bus_out     = cyc_addr[DATA_W-1:0];
        unique case (tst)
            TS_1: begin
                addr_strobe = 1'b1;
                bus_oe      = 1'b1;
            end
            TS_2, TS_3: begin
                if (is_wr) begin
                    wr_n    = 1'b0;
                    bus_oe  = 1'b1;
                    bus_out = acc;
                end else begin
                    rd_n    = 1'b0;
                end
            end
            TS_4: bus_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/ioseq_core.sv
module ioseq_core
    import ioseq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] addr_hi,
    output logic              addr_strobe,
    output logic              io_cycle,
    output logic              rd_n,
    output logic              wr_n
);

    localparam int unsigned ADDR_W = 2 * DATA_W;

    kind_e             kind;
    mcyc_e             mcyc;
    tstate_e           tst;
    reg_ctl_t          rctl;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] opcode;
    logic [DATA_W-1:0] opnd_lo;
    logic [DATA_W-1:0] opnd_hi;
    logic [DATA_W-1:0] acc;

    ioseq_decode #(.DATA_W(DATA_W)) u_decode (
        .opcode (opcode),
        .kind   (kind)
    );

    ioseq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .mcyc  (mcyc),
        .tst   (tst),
        .rctl  (rctl)
    );

    ioseq_regs #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rctl    (rctl),
        .bus_in  (bus_in),
        .pc      (pc),
        .opcode  (opcode),
        .opnd_lo (opnd_lo),
        .opnd_hi (opnd_hi),
        .acc     (acc)
    );

    ioseq_busdrv #(.DATA_W(DATA_W)) u_busdrv (
        .mcyc        (mcyc),
        .tst         (tst),
        .pc          (pc),
        .opnd_lo     (opnd_lo),
        .opnd_hi     (opnd_hi),
        .acc         (acc),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .addr_hi     (addr_hi),
        .addr_strobe (addr_strobe),
        .io_cycle    (io_cycle),
        .rd_n        (rd_n),
        .wr_n        (wr_n)
    );

endmodule

// File: rtl/ioseq_chk.sv
module ioseq_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic [DATA_W-1:0] addr_hi,
    input logic              addr_strobe,
    input logic              io_cycle,
    input logic              rd_n,
    input logic              wr_n
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

    // R9
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe);

    // R2
    strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> (!rd_n || !wr_n));

    // R10
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |=> (!wr_n && $stable(bus_out) && bus_oe));

    // R4
    write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !$fell(wr_n)) |=> wr_n);

    // R5
    port_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && io_cycle) |-> (addr_hi == bus_out));

    // R6
    io_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe && !$fell(addr_strobe) && !$rose(addr_strobe)) |-> $stable(io_cycle));

endmodule

bind ioseq_core ioseq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .addr_hi     (addr_hi),
    .addr_strobe (addr_strobe),
    .io_cycle    (io_cycle),
    .rd_n        (rd_n),
    .wr_n        (wr_n)
);

// File: tb/ioseq_core_test.sv
module ioseq_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] addr_hi;
    logic       addr_strobe;
    logic       io_cycle;
    logic       rd_n;
    logic       wr_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  mem [0:4095];
    logic [15:0] m_pc;
    logic [7:0]  m_acc;
    bit          first_out;

    ioseq_core uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_in      (bus_in),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .addr_hi     (addr_hi),
        .addr_strobe (addr_strobe),
        .io_cycle    (io_cycle),
        .rd_n        (rd_n),
        .wr_n        (wr_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit known_op(logic [7:0] o);
        return (o == 8'hD3) || (o == 8'hDB) || (o == 8'h32) || (o == 8'h3A);
    endfunction

    // Check one T-state at a falling edge, then advance to the next one
    task automatic step(string tag, logic e_ale, logic e_io, logic e_rd, logic e_wr,
                        logic e_oe, logic [7:0] e_hi, logic [7:0] e_lo);
        logic [20:0] act;
        logic [20:0] exp;
        act = {addr_strobe, io_cycle, rd_n, wr_n, bus_oe, addr_hi, (e_oe ? bus_out : 8'h00)};
        exp = {e_ale, e_io, e_rd, e_wr, e_oe, e_hi, (e_oe ? e_lo : 8'h00)};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ale/io/rd/wr/oe/hi/lo got %h expected %h at %0t", tag, act, exp, $time);
        end
        checks++;
        if (rd_n === 1'b0 && wr_n === 1'b0) begin
            errors++;
            $display("FAIL R9: rd_n/wr_n got 0/0 expected not both low at %0t", $time);
        end
        checks++;
        if (rd_n === 1'b0 && bus_oe !== 1'b0) begin
            errors++;
            $display("FAIL R10: bus_oe got %b expected 0 during read at %0t", bus_oe, $time);
        end
        @(negedge clk);
    endtask

    // One machine cycle: T1, two strobe T-states, and T4 for fetches
    task automatic bus_cycle(string tag, bit fetch, bit io, bit wr,
                             logic [15:0] a, logic [7:0] d);
        step(tag, 1'b1, io, 1'b1, 1'b1, 1'b1, a[15:8], a[7:0]);
        if (!wr) bus_in = d;
        repeat (2) step(tag, 1'b0, io, wr, !wr, wr, a[15:8], d);
        if (fetch) step(tag, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, a[15:8], 8'h00);
    endtask

    // Run one instruction from the model PC; returns 1 for an unknown opcode
    task automatic exec_instr(string ftag, output bit unknown);
        logic [7:0]  op;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [7:0]  v;
        logic [15:0] a;
        op = mem[m_pc[11:0]];
        bus_cycle(ftag, 1'b1, 1'b0, 1'b0, m_pc, op);
        m_pc++;
        unknown = 1'b0;
        case (op)
            8'hD3: begin
                lo = mem[m_pc[11:0]];
                bus_cycle("R3", 1'b0, 1'b0, 1'b0, m_pc, lo);
                m_pc++;
                bus_cycle(first_out ? "R11" : "R4", 1'b0, 1'b1, 1'b1, {lo, lo}, m_acc);
                first_out = 1'b0;
            end
            8'hDB: begin
                lo = mem[m_pc[11:0]];
                bus_cycle("R3", 1'b0, 1'b0, 1'b0, m_pc, lo);
                m_pc++;
                v = 8'($urandom);
                bus_cycle("R5", 1'b0, 1'b1, 1'b0, {lo, lo}, v);
                m_acc = v;
            end
            8'h32, 8'h3A: begin
                lo = mem[m_pc[11:0]];
                bus_cycle("R3", 1'b0, 1'b0, 1'b0, m_pc, lo);
                m_pc++;
                hi = mem[m_pc[11:0]];
                bus_cycle("R3", 1'b0, 1'b0, 1'b0, m_pc, hi);
                m_pc++;
                a = {hi, lo};
                if (op == 8'h32) begin
                    bus_cycle("R6", 1'b0, 1'b0, 1'b1, a, m_acc);
                    mem[a[11:0]] = m_acc;
                end else begin
                    v = mem[a[11:0]];
                    bus_cycle("R7", 1'b0, 1'b0, 1'b0, a, v);
                    m_acc = v;
                end
            end
            default: unknown = 1'b1;
        endcase
    endtask

    task automatic put(inout int p, input logic [7:0] b);
        mem[p] = b;
        p++;
    endtask

    initial begin
        int  p;
        bit  unk;
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        mem[12'hFFF] = 8'hA5;
        p = 0;
        // Directed prologue
        put(p, 8'hD3); put(p, 8'h00);                  // output of reset accumulator
        put(p, 8'h3A); put(p, 8'hFF); put(p, 8'h0F);   // load from 0FFFH
        put(p, 8'h00);                                 // unknown opcode
        put(p, 8'hD3); put(p, 8'hFF);                  // port FFH
        put(p, 8'hDB); put(p, 8'h80);                  // input
        put(p, 8'h32); put(p, 8'h00); put(p, 8'h08);   // store to 0800H
        put(p, 8'hC7);                                 // unknown opcode
        put(p, 8'h3A); put(p, 8'h00); put(p, 8'h08);   // load back
        put(p, 8'hD3); put(p, 8'h42);
        // Random body
        for (int k = 0; k < N_RAND; k++) begin
            logic [7:0]  o;
            logic [15:0] ra;
            ra = {4'h0, 1'b1, 11'($urandom)};
            case ($urandom_range(0, 4))
                0: begin put(p, 8'hD3); put(p, 8'($urandom)); end
                1: begin put(p, 8'hDB); put(p, 8'($urandom)); end
                2: begin put(p, 8'h32); put(p, ra[7:0]); put(p, ra[15:8]); end
                3: begin put(p, 8'h3A); put(p, ra[7:0]); put(p, ra[15:8]); end
                default: begin
                    o = 8'($urandom);
                    while (known_op(o)) o = 8'($urandom);
                    put(p, o);
                end
            endcase
        end

        m_pc      = 16'h0000;
        m_acc     = 8'h00;
        first_out = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        checks++;
        if ({addr_strobe, rd_n, wr_n, io_cycle, addr_hi, bus_out} !== {4'b1110, 16'h0000}) begin
            errors++;
            $display("FAIL R1: reset outputs got %b_%h%h expected 1110_0000", {addr_strobe, rd_n, wr_n, io_cycle}, addr_hi, bus_out);
        end
        rst_n = 1'b1;

        unk = 1'b0;
        exec_instr("R1", unk);
        for (int n = 0; n < 8 + N_RAND; n++) begin
            bit prev;
            prev = unk;
            exec_instr(prev ? "R8" : "R2", unk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run got no end expected end before 200000 cycles");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule